// File: doc/BRIEF.md
# Virtually Indexed, Virtually Tagged Direct-Mapped Cache Controller

This block is the control logic and storage of a level-one cache that is looked up with the virtual address alone. It holds 512 lines of 64 bytes, one line per index, and serves CPU loads and stores with 32-bit words. Tag and data are read in the same cycle the request is accepted, so a run of hits completes at one request per clock. Stores that hit update the cached word and are forwarded to memory at once (write-through). Stores that miss allocate the line.

On a miss, the controller sends a line request towards the translation side and stalls. It waits for a synonym message first. That message names one line index to clear, or says there is nothing to clear. Only after that does it take the refill line, install it and answer the CPU. Coherence invalidates from the memory system name a line index. They are taken only while no miss is in flight, so a refill can never overtake an invalidate.

Top module: `vivt_dm_cache`

## Requirements
- R1: After reset every line is invalid, `req_ready` and `snp_ready` are 1, and `rsp_valid` and `mmu_req_valid` are 0.
- R2: A load that hits is answered in the cycle after acceptance. `rsp_valid` is 1 and `rsp_rdata` holds the addressed word. `req_ready` stays 1, so consecutive hits are accepted on every clock.
- R3: A store that hits writes its word into the line. In the cycle after acceptance it raises `wt_valid` with `wt_addr` set to the request address and `wt_data` set to the store word. In that same cycle it raises `rsp_valid`, with `rsp_rdata` equal to the store word. No MMU request is made.
- R4: On a miss, `mmu_req_valid` is high for exactly one cycle, in the cycle after acceptance. It carries the request address, the write flag and the store word. `req_ready` stays 0 until the refill is taken.
- R5: A refill beat offered before the synonym message is ignored. It produces no response and leaves `req_ready` at 0.
- R6: A synonym message clears the line at `syn_index` unless `syn_none` is 1. With `syn_none` at 1, no line is touched.
- R7: When a refill without error is taken, the tag and line are written. `rsp_valid` rises in the next cycle with the requested word for a load. `req_ready` is 1 from that cycle on.
- R8: A store miss sends its word with the line request. That word is merged into the refilled line, and the other words of the line come from the refill.
- R9: A refill with `fill_err` at 1 leaves the line invalid and answers with `rsp_err` at 1. A later access to the same address misses again.
- R10: In the idle state, a snoop clears line `snp_index` at the clock edge. A load accepted in the same cycle to that line still returns the data held before the clear. The next access to that line misses.
- R11: `snp_ready` is 0 while a miss is in flight, so a held snoop is taken only once the controller is idle again.
- R12: Word select is address bits [5:2], line index is bits [14:6] and tag is bits [31:15]. Two addresses with the same index but different tags replace each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | CPU request present |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 32 | Virtual byte address |
| req_wdata | input | 32 | Store word |
| req_ready | output | 1 | Request is accepted this cycle |
| rsp_valid | output | 1 | Response to the CPU |
| rsp_err | output | 1 | Refill failed |
| rsp_rdata | output | 32 | Load word, or store word for stores |
| wt_valid | output | 1 | Write-through of a store hit |
| wt_addr | output | 32 | Write-through address |
| wt_data | output | 32 | Write-through word |
| snp_valid | input | 1 | Coherence invalidate present |
| snp_index | input | 9 | Line index to invalidate |
| snp_ready | output | 1 | Invalidate is taken this cycle |
| mmu_req_valid | output | 1 | Line request pulse |
| mmu_req_write | output | 1 | Line request comes from a store |
| mmu_req_addr | output | 32 | Virtual address of the miss |
| mmu_req_wdata | output | 32 | Store word for memory write-through |
| syn_valid | input | 1 | Synonym message present |
| syn_none | input | 1 | Nothing to clear |
| syn_index | input | 9 | Line index to clear |
| fill_valid | input | 1 | Refill line present |
| fill_err | input | 1 | Refill failed |
| fill_data | input | 512 | Refill line, word 0 in the low bits |

## Verification
A coherence invalidate and a CPU lookup can both happen in one idle cycle. The bench provokes this by driving a snoop and a load to the same line on the same edge. It passes only if the load returns the old word and the following access to that line misses. The second overlap is a snoop held high across a whole miss. It must stay untaken while `snp_ready` is 0 and be taken on the first idle edge. The bench shows this by forcing a miss on the snooped line afterwards.

// File: rtl/vivt_pkg.sv
// Shared types for the virtually tagged cache controller.
// Assumes nothing beyond IEEE 1800-2017 enums.
package vivt_pkg;

    // Controller phase: idle lookups, waiting for synonym message, waiting for refill.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SYN  = 2'd1,
        ST_FILL = 2'd2
    } ctl_state_e;

endpackage

// File: rtl/vivt_tag_store.sv
// Valid bits and virtual tags, one entry per line.
// Reads are combinational at rd_idx. A clear has priority over a set in the same cycle.
// Assumes the caller never needs a cleared line to be set again in that cycle.
module vivt_tag_store #(
    parameter int LINES = 512,
    parameter int TAG_W = 17,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic [TAG_W-1:0] rd_tag,
    input  logic             set_en,
    input  logic [IDX_W-1:0] set_idx,
    input  logic [TAG_W-1:0] set_tag,
    input  logic             clr_en,
    input  logic [IDX_W-1:0] clr_idx
);

    logic [LINES-1:0] valid_q;
    logic [TAG_W-1:0] tag_q [LINES];

    // Valid bits: reset to empty, clear wins over set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (clr_en) begin
            valid_q[clr_idx] <= 1'b0;
        end else if (set_en) begin
            valid_q[set_idx] <= 1'b1;
        end
    end

    // Tag array: written only on an installed refill.
    always_ff @(posedge clk) begin
        if (set_en) begin
            tag_q[set_idx] <= set_tag;
        end
    end

    // Combinational lookup port.
    always_comb begin
        rd_valid = valid_q[rd_idx];
        rd_tag   = tag_q[rd_idx];
    end

    // R6 R9 R10
    clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> !valid_q[$past(clr_idx)]);

endmodule

// File: rtl/vivt_line_store.sv
// Line data storage: one full line per entry, read combinationally.
// Accepts a whole-line write (refill) or a single-word write (store hit).
// Assumes both write kinds never occur in the same cycle.
module vivt_line_store #(
    parameter int LINES  = 512,
    parameter int LINE_W = 512,
    parameter int WORD_W = 32,
    localparam int IDX_W  = $clog2(LINES),
    localparam int WSEL_W = $clog2(LINE_W / WORD_W)
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [LINE_W-1:0] rd_line,
    input  logic              line_we,
    input  logic [IDX_W-1:0]  line_idx,
    input  logic [LINE_W-1:0] line_data,
    input  logic              word_we,
    input  logic [IDX_W-1:0]  word_idx,
    input  logic [WSEL_W-1:0] word_sel,
    input  logic [WORD_W-1:0] word_data
);

    logic [LINE_W-1:0] mem_q [LINES];

    // Write port: full line on refill, one word on store hit.
    always_ff @(posedge clk) begin
        if (line_we) begin
            mem_q[line_idx] <= line_data;
        end else if (word_we) begin
            mem_q[word_idx][word_sel*WORD_W +: WORD_W] <= word_data;
        end
    end

    // Combinational read of the addressed line.
    always_comb begin
        rd_line = mem_q[rd_idx];
    end

endmodule

// File: rtl/vivt_ctrl.sv
// Request sequencer: hit path, miss handshake (line request, synonym message, refill),
// and snoop sampling. Snoops are taken only in the idle phase.
// Assumes the MMU side sends exactly one synonym message per line request, then one refill.
module vivt_ctrl
    import vivt_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int WORD_W     = 32,
    parameter int LINE_BYTES = 64,
    parameter int LINES      = 512,
    localparam int OFF_W  = $clog2(LINE_BYTES),
    localparam int IDX_W  = $clog2(LINES),
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W,
    localparam int BOFF_W = $clog2(WORD_W / 8),
    localparam int WSEL_W = OFF_W - BOFF_W,
    localparam int LINE_W = LINE_BYTES * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [WORD_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [WORD_W-1:0] rsp_rdata,
    output logic              wt_valid,
    output logic [ADDR_W-1:0] wt_addr,
    output logic [WORD_W-1:0] wt_data,
    input  logic              snp_valid,
    input  logic [IDX_W-1:0]  snp_index,
    output logic              snp_ready,
    output logic              mmu_req_valid,
    output logic              mmu_req_write,
    output logic [ADDR_W-1:0] mmu_req_addr,
    output logic [WORD_W-1:0] mmu_req_wdata,
    input  logic              syn_valid,
    input  logic              syn_none,
    input  logic [IDX_W-1:0]  syn_index,
    input  logic              fill_valid,
    input  logic              fill_err,
    input  logic [LINE_W-1:0] fill_data,
    output logic [IDX_W-1:0]  lk_idx,
    input  logic              lk_valid,
    input  logic [TAG_W-1:0]  lk_tag,
    input  logic [LINE_W-1:0] lk_line,
    output logic              tg_set_en,
    output logic [IDX_W-1:0]  tg_set_idx,
    output logic [TAG_W-1:0]  tg_set_tag,
    output logic              tg_clr_en,
    output logic [IDX_W-1:0]  tg_clr_idx,
    output logic              ln_we,
    output logic [LINE_W-1:0] ln_data,
    output logic              wd_we,
    output logic [WSEL_W-1:0] wd_sel
);

    ctl_state_e        state_q;
    logic [ADDR_W-1:0] pend_addr_q;
    logic              pend_write_q;
    logic [WORD_W-1:0] pend_wdata_q;
    logic              rsp_valid_q, rsp_err_q, wt_valid_q, mmu_valid_q;
    logic [WORD_W-1:0] rsp_rdata_q, wt_data_q;
    logic [ADDR_W-1:0] wt_addr_q;

    logic              in_idle, accept, hit, syn_take, fill_take;
    logic [TAG_W-1:0]  req_tag, pend_tag;
    logic [IDX_W-1:0]  pend_idx;
    logic [WSEL_W-1:0] req_sel, pend_sel;
    logic [WORD_W-1:0] hit_word, fill_word;

    // Field extraction, hit detect and array control for the current cycle.
    always_comb begin
        lk_idx   = req_addr[OFF_W +: IDX_W];
        req_tag  = req_addr[OFF_W+IDX_W +: TAG_W];
        req_sel  = req_addr[BOFF_W +: WSEL_W];
        pend_idx = pend_addr_q[OFF_W +: IDX_W];
        pend_tag = pend_addr_q[OFF_W+IDX_W +: TAG_W];
        pend_sel = pend_addr_q[BOFF_W +: WSEL_W];

        in_idle   = (state_q == ST_IDLE);
        accept    = in_idle && req_valid;
        hit       = lk_valid && (lk_tag == req_tag);
        hit_word  = lk_line[req_sel*WORD_W +: WORD_W];
        syn_take  = (state_q == ST_SYN) && syn_valid;
        fill_take = (state_q == ST_FILL) && fill_valid;

        tg_clr_en  = 1'b0;
        tg_clr_idx = snp_index;
        if (in_idle && snp_valid) begin
            tg_clr_en  = 1'b1;
        end else if (syn_take && !syn_none) begin
            tg_clr_en  = 1'b1;
            tg_clr_idx = syn_index;
        end else if (fill_take && fill_err) begin
            tg_clr_en  = 1'b1;
            tg_clr_idx = pend_idx;
        end

        ln_data = fill_data;
        if (pend_write_q) begin
            ln_data[pend_sel*WORD_W +: WORD_W] = pend_wdata_q;
        end
        fill_word = ln_data[pend_sel*WORD_W +: WORD_W];

        ln_we      = fill_take && !fill_err;
        tg_set_en  = ln_we;
        tg_set_idx = pend_idx;
        tg_set_tag = pend_tag;

        wd_we  = accept && hit && req_write;
        wd_sel = req_sel;
    end

    // Phase register, pending miss and registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            pend_addr_q  <= '0;
            pend_write_q <= 1'b0;
            pend_wdata_q <= '0;
            rsp_valid_q  <= 1'b0;
            rsp_err_q    <= 1'b0;
            rsp_rdata_q  <= '0;
            wt_valid_q   <= 1'b0;
            wt_addr_q    <= '0;
            wt_data_q    <= '0;
            mmu_valid_q  <= 1'b0;
        end else begin
            rsp_valid_q <= 1'b0;
            rsp_err_q   <= 1'b0;
            wt_valid_q  <= 1'b0;
            mmu_valid_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (accept && hit) begin
                        rsp_valid_q <= 1'b1;
                        rsp_rdata_q <= req_write ? req_wdata : hit_word;
                        if (req_write) begin
                            wt_valid_q <= 1'b1;
                            wt_addr_q  <= req_addr;
                            wt_data_q  <= req_wdata;
                        end
                    end else if (accept) begin
                        pend_addr_q  <= req_addr;
                        pend_write_q <= req_write;
                        pend_wdata_q <= req_wdata;
                        mmu_valid_q  <= 1'b1;
                        state_q      <= ST_SYN;
                    end
                end
                ST_SYN: begin
                    if (syn_valid) begin
                        state_q <= ST_FILL;
                    end
                end
                ST_FILL: begin
                    if (fill_valid) begin
                        rsp_valid_q <= 1'b1;
                        rsp_err_q   <= fill_err;
                        rsp_rdata_q <= fill_err ? '0 : fill_word;
                        state_q     <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Port drive from registers and phase.
    always_comb begin
        req_ready     = in_idle;
        snp_ready     = in_idle;
        rsp_valid     = rsp_valid_q;
        rsp_err       = rsp_err_q;
        rsp_rdata     = rsp_rdata_q;
        wt_valid      = wt_valid_q;
        wt_addr       = wt_addr_q;
        wt_data       = wt_data_q;
        mmu_req_valid = mmu_valid_q;
        mmu_req_write = pend_write_q;
        mmu_req_addr  = pend_addr_q;
        mmu_req_wdata = pend_wdata_q;
    end

    // R4
    mmu_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mmu_req_valid |=> !mmu_req_valid);

    // R11
    snoop_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mmu_req_valid |-> !snp_ready);

    // R3
    wt_with_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wt_valid |-> (rsp_valid && !rsp_err));

    // R9
    err_after_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> $past(fill_valid));

endmodule

// File: rtl/vivt_dm_cache.sv
// Top of the virtually indexed, virtually tagged direct-mapped cache.
// Connects the sequencer to the tag store and line store.
// Assumes a 32-bit virtual address and a refill delivered as one full-line beat.
module vivt_dm_cache #(
    parameter int ADDR_W     = 32,
    parameter int WORD_W     = 32,
    parameter int LINE_BYTES = 64,
    parameter int LINES      = 512,
    localparam int OFF_W  = $clog2(LINE_BYTES),
    localparam int IDX_W  = $clog2(LINES),
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W,
    localparam int WSEL_W = OFF_W - $clog2(WORD_W / 8),
    localparam int LINE_W = LINE_BYTES * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [WORD_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [WORD_W-1:0] rsp_rdata,
    output logic              wt_valid,
    output logic [ADDR_W-1:0] wt_addr,
    output logic [WORD_W-1:0] wt_data,
    input  logic              snp_valid,
    input  logic [IDX_W-1:0]  snp_index,
    output logic              snp_ready,
    output logic              mmu_req_valid,
    output logic              mmu_req_write,
    output logic [ADDR_W-1:0] mmu_req_addr,
    output logic [WORD_W-1:0] mmu_req_wdata,
    input  logic              syn_valid,
    input  logic              syn_none,
    input  logic [IDX_W-1:0]  syn_index,
    input  logic              fill_valid,
    input  logic              fill_err,
    input  logic [LINE_W-1:0] fill_data
);

    logic [IDX_W-1:0]  lk_idx, tg_set_idx, tg_clr_idx;
    logic              lk_valid, tg_set_en, tg_clr_en, ln_we, wd_we;
    logic [TAG_W-1:0]  lk_tag, tg_set_tag;
    logic [LINE_W-1:0] lk_line, ln_data;
    logic [WSEL_W-1:0] wd_sel;

    vivt_ctrl #(
        .ADDR_W(ADDR_W), .WORD_W(WORD_W), .LINE_BYTES(LINE_BYTES), .LINES(LINES)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .wt_valid(wt_valid), .wt_addr(wt_addr), .wt_data(wt_data),
        .snp_valid(snp_valid), .snp_index(snp_index), .snp_ready(snp_ready),
        .mmu_req_valid(mmu_req_valid), .mmu_req_write(mmu_req_write),
        .mmu_req_addr(mmu_req_addr), .mmu_req_wdata(mmu_req_wdata),
        .syn_valid(syn_valid), .syn_none(syn_none), .syn_index(syn_index),
        .fill_valid(fill_valid), .fill_err(fill_err), .fill_data(fill_data),
        .lk_idx(lk_idx), .lk_valid(lk_valid), .lk_tag(lk_tag), .lk_line(lk_line),
        .tg_set_en(tg_set_en), .tg_set_idx(tg_set_idx), .tg_set_tag(tg_set_tag),
        .tg_clr_en(tg_clr_en), .tg_clr_idx(tg_clr_idx),
        .ln_we(ln_we), .ln_data(ln_data), .wd_we(wd_we), .wd_sel(wd_sel)
    );

    vivt_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(lk_idx), .rd_valid(lk_valid), .rd_tag(lk_tag),
        .set_en(tg_set_en), .set_idx(tg_set_idx), .set_tag(tg_set_tag),
        .clr_en(tg_clr_en), .clr_idx(tg_clr_idx)
    );

    vivt_line_store #(.LINES(LINES), .LINE_W(LINE_W), .WORD_W(WORD_W)) u_lines (
        .clk(clk),
        .rd_idx(lk_idx), .rd_line(lk_line),
        .line_we(ln_we), .line_idx(tg_set_idx), .line_data(ln_data),
        .word_we(wd_we), .word_idx(lk_idx), .word_sel(wd_sel), .word_data(req_wdata)
    );

endmodule

// File: tb/vivt_dm_cache_tb.sv
// Directed bench: one task per scenario, each checking its own results.
module vivt_dm_cache_tb;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0, req_write = 1'b0;
    logic [31:0]  req_addr = '0, req_wdata = '0;
    logic         req_ready, rsp_valid, rsp_err, wt_valid, snp_ready;
    logic [31:0]  rsp_rdata, wt_addr, wt_data, mmu_req_addr, mmu_req_wdata;
    logic         snp_valid = 1'b0;
    logic [8:0]   snp_index = '0;
    logic         mmu_req_valid, mmu_req_write;
    logic         syn_valid = 1'b0, syn_none = 1'b0;
    logic [8:0]   syn_index = '0;
    logic         fill_valid = 1'b0, fill_err = 1'b0;
    logic [511:0] fill_data = '0;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #5 clk = ~clk;

    vivt_dm_cache u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .wt_valid(wt_valid), .wt_addr(wt_addr), .wt_data(wt_data),
        .snp_valid(snp_valid), .snp_index(snp_index), .snp_ready(snp_ready),
        .mmu_req_valid(mmu_req_valid), .mmu_req_write(mmu_req_write),
        .mmu_req_addr(mmu_req_addr), .mmu_req_wdata(mmu_req_wdata),
        .syn_valid(syn_valid), .syn_none(syn_none), .syn_index(syn_index),
        .fill_valid(fill_valid), .fill_err(fill_err), .fill_data(fill_data)
    );

    function automatic logic [31:0] mk(input logic [16:0] t, input logic [8:0] i, input logic [3:0] w);
        return {t, i, w, 2'b00};
    endfunction

    function automatic logic [511:0] pat(input logic [15:0] seed);
        logic [511:0] l;
        for (int i = 0; i < 16; i++) l[i*32 +: 32] = {seed, 16'(i)};
        return l;
    endfunction

    task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    // Present one request; returns just after the accepting edge.
    task automatic issue(input logic wr, input logic [31:0] a, input logic [31:0] wd);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
        while (!req_ready) @(negedge clk);
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic hit_load(input logic [31:0] a, input logic [31:0] exp, input string rq);
        issue(1'b0, a, '0);
        chk(rq, "hit rsp_valid", {31'b0, rsp_valid}, 32'd1);
        chk(rq, "hit rdata", rsp_rdata, exp);
        chk(rq, "hit no mmu request", {31'b0, mmu_req_valid}, 32'd0);
    endtask

    // Full miss handshake with optional early refill and held snoop.
    task automatic run_miss(input logic wr, input logic [31:0] a, input logic [31:0] wd,
                            input logic none, input logic [8:0] sidx, input logic [15:0] seed,
                            input logic err, input logic early, input logic hold,
                            input logic [8:0] hidx, input string rq);
        issue(wr, a, wd);
        chk(rq, "mmu_req_valid", {31'b0, mmu_req_valid}, 32'd1);
        chk(rq, "mmu_req_addr", mmu_req_addr, a);
        chk(rq, "mmu_req_write", {31'b0, mmu_req_write}, {31'b0, wr});
        if (wr) chk(rq, "mmu_req_wdata", mmu_req_wdata, wd);
        chk(rq, "req_ready low in miss", {31'b0, req_ready}, 32'd0);
        if (hold) begin
            snp_valid = 1'b1; snp_index = hidx;
            chk(rq, "snp_ready low in miss", {31'b0, snp_ready}, 32'd0);
        end
        if (early) begin
            @(negedge clk); fill_valid = 1'b1; fill_err = 1'b0; fill_data = pat(16'hEEEE);
            @(posedge clk); #1; fill_valid = 1'b0;
            chk(rq, "early refill no rsp", {31'b0, rsp_valid}, 32'd0);
            chk(rq, "early refill still busy", {31'b0, req_ready}, 32'd0);
        end
        @(negedge clk); syn_valid = 1'b1; syn_none = none; syn_index = sidx;
        @(posedge clk); #1; syn_valid = 1'b0;
        @(negedge clk); fill_valid = 1'b1; fill_err = err; fill_data = pat(seed);
        @(posedge clk); #1; fill_valid = 1'b0; fill_err = 1'b0;
        chk(rq, "refill rsp_valid", {31'b0, rsp_valid}, 32'd1);
        chk(rq, "refill rsp_err", {31'b0, rsp_err}, {31'b0, err});
        if (!err && !wr) chk(rq, "refill word", rsp_rdata, {seed, 12'b0, a[5:2]});
        chk(rq, "ready after refill", {31'b0, req_ready}, 32'd1);
        if (hold) begin
            @(negedge clk);
            chk(rq, "snp_ready after miss", {31'b0, snp_ready}, 32'd1);
            @(posedge clk); #1; snp_valid = 1'b0;
        end
    endtask

    task automatic t_reset();
        chk("R1", "req_ready", {31'b0, req_ready}, 32'd1);
        chk("R1", "snp_ready", {31'b0, snp_ready}, 32'd1);
        chk("R1", "rsp_valid", {31'b0, rsp_valid}, 32'd0);
        chk("R1", "mmu_req_valid", {31'b0, mmu_req_valid}, 32'd0);
    endtask

    // Back-to-back hits, one per clock (R2).
    task automatic t_back_to_back(input logic [31:0] a0, input logic [31:0] e0,
                                  input logic [31:0] a1, input logic [31:0] e1);
        @(negedge clk); req_valid = 1'b1; req_write = 1'b0; req_addr = a0;
        @(posedge clk); #1; req_addr = a1;
        chk("R2", "first rsp_valid", {31'b0, rsp_valid}, 32'd1);
        chk("R2", "first rdata", rsp_rdata, e0);
        chk("R2", "ready between hits", {31'b0, req_ready}, 32'd1);
        @(posedge clk); #1; req_valid = 1'b0;
        chk("R2", "second rsp_valid", {31'b0, rsp_valid}, 32'd1);
        chk("R2", "second rdata", rsp_rdata, e1);
    endtask

    task automatic t_store_hit(input logic [31:0] a, input logic [31:0] wd);
        issue(1'b1, a, wd);
        chk("R3", "wt_valid", {31'b0, wt_valid}, 32'd1);
        chk("R3", "wt_addr", wt_addr, a);
        chk("R3", "wt_data", wt_data, wd);
        chk("R3", "rsp rdata", rsp_rdata, wd);
        chk("R3", "no mmu request", {31'b0, mmu_req_valid}, 32'd0);
        hit_load(a, wd, "R3");
    endtask

    // Snoop and load to the same line in the same idle cycle (R10).
    task automatic t_snoop_same_cycle(input logic [31:0] a, input logic [31:0] old);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        snp_valid = 1'b1; snp_index = a[14:6];
        @(posedge clk); #1;
        req_valid = 1'b0; snp_valid = 1'b0;
        chk("R10", "same-cycle rsp_valid", {31'b0, rsp_valid}, 32'd1);
        chk("R10", "same-cycle old data", rsp_rdata, old);
        run_miss(1'b0, a, '0, 1'b1, '0, 16'h00A2, 1'b0, 1'b0, 1'b0, '0, "R10");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R7 watchdog: actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] a_a, a_b, a_c, a_d, a_e, a_f, a_g;
        a_a = mk(17'h5, 9'd3, 4'd2);
        a_b = mk(17'h5, 9'd10, 4'd0);
        a_c = mk(17'h9, 9'd20, 4'd1);
        a_d = mk(17'h7, 9'd40, 4'd5);
        a_e = mk(17'h3, 9'd50, 4'd0);
        a_f = mk(17'hB, 9'd60, 4'd0);
        a_g = mk(17'h6, 9'd3, 4'd2);

        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        t_reset();

        // R1 R4 R5 R7: cold miss with an early refill beat.
        run_miss(1'b0, a_a, '0, 1'b1, '0, 16'h00A0, 1'b0, 1'b1, 1'b0, '0, "R4");
        t_back_to_back(a_a, 32'h00A0_0002, mk(17'h5, 9'd3, 4'd7), 32'h00A0_0007);
        t_store_hit(mk(17'h5, 9'd3, 4'd7), 32'hDEAD_0007);

        // R6: synonym "none" keeps A; synonym naming A's index clears it.
        run_miss(1'b0, a_b, '0, 1'b1, '0, 16'h00B0, 1'b0, 1'b0, 1'b0, '0, "R6");
        hit_load(a_a, 32'h00A0_0002, "R6");
        run_miss(1'b0, a_c, '0, 1'b0, 9'd3, 16'h00C0, 1'b0, 1'b0, 1'b0, '0, "R6");
        run_miss(1'b0, a_a, '0, 1'b1, '0, 16'h00A1, 1'b0, 1'b0, 1'b0, '0, "R6");

        // R8: store miss merge.
        run_miss(1'b1, a_d, 32'h1234_5678, 1'b1, '0, 16'h00D0, 1'b0, 1'b0, 1'b0, '0, "R8");
        hit_load(a_d, 32'h1234_5678, "R8");
        hit_load(mk(17'h7, 9'd40, 4'd6), 32'h00D0_0006, "R8");

        // R9: refill error, then a fresh miss on the same address.
        run_miss(1'b0, a_e, '0, 1'b1, '0, 16'h00E0, 1'b1, 1'b0, 1'b0, '0, "R9");
        run_miss(1'b0, a_e, '0, 1'b1, '0, 16'h00E1, 1'b0, 1'b0, 1'b0, '0, "R9");

        // R10: snoop and load on one edge.
        t_snoop_same_cycle(a_a, 32'h00A1_0002);

        // R11: snoop to C held across a miss, applied once idle; C then misses.
        run_miss(1'b0, a_f, '0, 1'b1, '0, 16'h00F0, 1'b0, 1'b0, 1'b1, 9'd20, "R11");
        run_miss(1'b0, a_c, '0, 1'b1, '0, 16'h00C1, 1'b0, 1'b0, 1'b0, '0, "R11");

        // R12: same index, other tag replaces A; A then misses.
        run_miss(1'b0, a_g, '0, 1'b1, '0, 16'h0060, 1'b0, 1'b0, 1'b0, '0, "R12");
        hit_load(a_g, 32'h0060_0002, "R12");
        run_miss(1'b0, a_a, '0, 1'b1, '0, 16'h00A3, 1'b0, 1'b0, 1'b0, '0, "R12");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule